// File: doc/BRIEF.md
# Latch Pipeline Bubble Stall Controller

This block supervises a linear chain of level-sensitive latches clocked by two non-overlapping phase enables. Even-numbered stages are transparent while `phase_a` is high and odd-numbered stages while `phase_b` is high. Each stage reports one strobe per cycle when its data input toggles. The controller classifies each toggle by where it falls relative to that stage's effective transparent window. It then hands out per-stage latch enables that withhold a transparent phase from stages that must wait.

A toggle inside the open window means the stage is borrowing time from downstream. That raises the timing-error flag and starts a stall token, or bubble, at both neighbours of the offending stage. Each bubble stops its holder's next transparent phase. When that skipped phase ends, the holder passes the bubble one stage further, away from the side it came from. The bubble dies at either end of the chain. A toggle in the closed interval just after a stage's window is a hard failure: it is reported on its own output and starts no bubble. The controller accumulates every withheld stage-phase in a saturating counter.

Top module: `latch_bubble_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all bubbles, both error outputs and `stall_count`. After reset, with both phases low, `latch_en` is all zero.
- R2: With no bubble held, `latch_en[s]` equals `phase_a` for even s and `phase_b` for odd s, in the same cycle.
- R3: A toggle that arrives while a stage's latch is closed and before its own phase opens sets neither error output and withholds no phase.
- R4: A toggle on stage s in a cycle where `latch_en[s]` is high drives `timing_err` high in the following cycle.
- R5: A toggle on stage s in the closed interval that runs from the end of its enabled phase until the opposite phase rises drives `fatal_err` high in the following cycle. It does not set `timing_err` and starts no bubble.
- R6: After a timing error on stage s, stages s-1 and s+1 (where they exist) keep `latch_en` low for the whole of their next phase.
- R7: A bubble moves one stage per phase, always away from the stage that sent it, so stage s±k skips the k-th phase after the error.
- R8: No bubble returns toward its origin: the stage that raised the error opens normally on its next phase.
- R9: During one error event a stage is withheld at most once. A bubble that reaches an already-stalled stage is dropped, even when two bubbles meet.
- R10: Bubbles reaching stage 0 or stage N-1 are absorbed. Once every bubble is gone, all enables follow their phases again.
- R11: `stall_count` grows by the number of stage-phases withheld, one cycle after each such phase ends. It saturates at its all-ones value (CNT_W bits, 16 by default) and never wraps.
- R12: A toggle on a stage whose phase is being withheld is not flagged as either kind of error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_a | input | 1 | Transparent-phase enable for even stages |
| phase_b | input | 1 | Transparent-phase enable for odd stages |
| din_tog | input | N_STAGE | Per-stage strobe: stage input toggled this cycle |
| latch_en | output | N_STAGE | Gated transparent enable for each latch |
| timing_err | output | 1 | A late toggle inside an open window was seen last cycle |
| fatal_err | output | 1 | A toggle after a window closed was seen last cycle |
| stall_count | output | CNT_W | Saturating total of withheld stage-phases |

## Verification
The checks assume that `phase_a` and `phase_b` are never high together. They also assume that each phase is followed by at least one cycle with both enables low, and that the two phases strictly alternate. Without these, a bubble handed on at a phase's end could reach a neighbour whose phase is already open, and the open and closed windows would stop being disjoint. The bench drives every phase as two high cycles, then one idle cycle, always A then B. All toggles are placed relative to that fixed schedule, and reset is held for three cycles so no history check ever reaches back across it.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  // direction a bubble is travelling; decides which neighbour gets it next
  typedef enum logic {
    GO_LEFT  = 1'b0,
    GO_RIGHT = 1'b1
  } travel_e;

  // number of set bits in a word
  function automatic logic [31:0] ones32(input logic [31:0] v);
    logic [31:0] n;
    n = '0;
    for (int i = 0; i < 32; i++) n = n + {31'd0, v[i]};
    return n;
  endfunction

  // add with a ceiling instead of wrap-around
  function automatic logic [31:0] sat_add(input logic [31:0] acc,
                                          input logic [31:0] inc,
                                          input logic [31:0] lim);
    logic [32:0] sum;
    sum = {1'b0, acc} + {1'b0, inc};
    return (sum > {1'b0, lim}) ? lim : sum[31:0];
  endfunction

endpackage

// File: rtl/lbs_detect.sv
module lbs_detect (
  input  logic clk,
  input  logic rst,
  input  logic en,       // effective (gated) transparent enable of this stage
  input  logic own_ph,   // raw phase this stage belongs to
  input  logic opp_ph,   // raw phase of the neighbours
  input  logic chg,      // data input toggled this cycle
  output logic late,
  output logic fatal
);
  logic en_q;
  logic shut_q;
  logic shut_win;

  // closed window: opens when an enabled phase ends, lasts until the other phase rises
  assign shut_win = (shut_q | (en_q & ~own_ph)) & ~opp_ph;
  assign late     = chg & en;
  assign fatal    = chg & shut_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      shut_q <= 1'b0;
    end else begin
      en_q   <= en;
      shut_q <= shut_win;
    end
  end

  // R5
  win_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(late && fatal))
    else $error("late and fatal windows overlap");

endmodule

// File: rtl/lbs_bubble_net.sv
module lbs_bubble_net #(
  parameter int N_STAGE = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_STAGE-1:0] own_ph,
  input  logic [N_STAGE-1:0] late,
  output logic [N_STAGE-1:0] pend,
  output logic [N_STAGE-1:0] stall_evt
);
  import lbs_pkg::*;

  logic [N_STAGE-1:0] own_q;
  logic [N_STAGE-1:0] fall;
  logic [N_STAGE-1:0] req_l;     // bubble coming from the lower-index side
  logic [N_STAGE-1:0] req_r;     // bubble coming from the higher-index side
  logic [N_STAGE-1:0] arrive;
  logic [N_STAGE-1:0] stalled;
  travel_e            dir [N_STAGE];

  assign fall      = own_q & ~own_ph;
  assign stall_evt = pend & fall;   // a withheld phase has just ended

  for (genvar s = 0; s < N_STAGE; s++) begin : g_link
    if (s == 0) begin : g_lo_end
      assign req_l[s] = 1'b0;
    end else begin : g_lo
      assign req_l[s] = late[s-1] | (stall_evt[s-1] & (dir[s-1] == GO_RIGHT));
    end
    if (s == N_STAGE-1) begin : g_hi_end
      assign req_r[s] = 1'b0;
    end else begin : g_hi
      assign req_r[s] = late[s+1] | (stall_evt[s+1] & (dir[s+1] == GO_LEFT));
    end

    always_ff @(posedge clk) begin
      if (rst)            dir[s] <= GO_RIGHT;
      else if (arrive[s]) dir[s] <= req_l[s] ? GO_RIGHT : GO_LEFT;
    end
  end

  assign arrive = (req_l | req_r) & ~stalled & ~pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q   <= '0;
      pend    <= '0;
      stalled <= '0;
    end else begin
      own_q   <= own_ph;
      pend    <= (pend & ~stall_evt) | arrive;
      stalled <= ((|pend) ? stalled : '0) | arrive;
    end
  end

  // R6
  pend_stable_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend ^ $past(pend)) & own_ph & $past(own_ph)) == '0)
    else $error("bubble changed during an open phase");

  // R9
  single_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (stall_evt & $past(stall_evt)) == '0)
    else $error("stage withheld on consecutive cycles");

endmodule

// File: rtl/lbs_stall_ctr.sv
module lbs_stall_ctr #(
  parameter int N_STAGE = 6,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_STAGE-1:0] evt,
  output logic [CNT_W-1:0]   count
);
  import lbs_pkg::*;

  localparam logic [31:0] LIM = 32'((64'd1 << CNT_W) - 64'd1);

  logic [31:0] inc;
  logic [31:0] nxt;

  assign inc = ones32(32'(evt));
  assign nxt = sat_add(32'(count), inc, LIM);

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= CNT_W'(nxt);
  end

  // R11
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    count >= $past(count))
    else $error("stall count went backwards");

  // R11
  step_max_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(count) - 32'($past(count))) <= 32'(N_STAGE))
    else $error("stall count jumped too far");

endmodule

// File: rtl/latch_bubble_ctrl.sv
module latch_bubble_ctrl #(
  parameter int N_STAGE = 6,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               phase_a,
  input  logic               phase_b,
  input  logic [N_STAGE-1:0] din_tog,
  output logic [N_STAGE-1:0] latch_en,
  output logic               timing_err,
  output logic               fatal_err,
  output logic [CNT_W-1:0]   stall_count
);
  logic [N_STAGE-1:0] own_ph;
  logic [N_STAGE-1:0] opp_ph;
  logic [N_STAGE-1:0] late;
  logic [N_STAGE-1:0] fatal;
  logic [N_STAGE-1:0] pend;
  logic [N_STAGE-1:0] stall_evt;

  for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
    if (s % 2 == 0) begin : g_even
      assign own_ph[s] = phase_a;
      assign opp_ph[s] = phase_b;
    end else begin : g_odd
      assign own_ph[s] = phase_b;
      assign opp_ph[s] = phase_a;
    end

    lbs_detect u_det (
      .clk    (clk),
      .rst    (rst),
      .en     (latch_en[s]),
      .own_ph (own_ph[s]),
      .opp_ph (opp_ph[s]),
      .chg    (din_tog[s]),
      .late   (late[s]),
      .fatal  (fatal[s])
    );
  end

  assign latch_en = own_ph & ~pend;

  lbs_bubble_net #(.N_STAGE(N_STAGE)) u_net (
    .clk       (clk),
    .rst       (rst),
    .own_ph    (own_ph),
    .late      (late),
    .pend      (pend),
    .stall_evt (stall_evt)
  );

  lbs_stall_ctr #(.N_STAGE(N_STAGE), .CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .evt   (stall_evt),
    .count (stall_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      timing_err <= 1'b0;
      fatal_err  <= 1'b0;
    end else begin
      timing_err <= |late;
      fatal_err  <= |fatal;
    end
  end

  // R2
  phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(phase_a && phase_b))
    else $error("phases overlap");

  // R7
  gap_a_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(phase_a) |-> !phase_b)
    else $error("no idle cycle after phase A");

  // R7
  gap_b_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(phase_b) |-> !phase_a)
    else $error("no idle cycle after phase B");

endmodule

// File: tb/sim_latch_bubble_ctrl.sv
`timescale 1ns/1ps
module sim_latch_bubble_ctrl;
  localparam int N = 6;
  localparam int CW = 6;
  localparam logic [CW-1:0] CMAX = '1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          phase_a = 1'b0;
  logic          phase_b = 1'b0;
  logic [N-1:0]  din_tog = '0;
  logic [N-1:0]  latch_en;
  logic          timing_err;
  logic          fatal_err;
  logic [CW-1:0] stall_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] base;

  always #2 clk = ~clk;

  latch_bubble_ctrl #(.N_STAGE(N), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .phase_a(phase_a), .phase_b(phase_b),
    .din_tog(din_tog), .latch_en(latch_en), .timing_err(timing_err),
    .fatal_err(fatal_err), .stall_count(stall_count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic b, input logic [N-1:0] tog);
    @(negedge clk);
    phase_a = a; phase_b = b; din_tog = tog;
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) drive(1'b0, 1'b0, '0);
    rst = 1'b0;
    drive(1'b0, 1'b0, '0);
    check("R1 latch_en", 32'(latch_en), 0);
    check("R1 timing_err", 32'(timing_err), 0);
    check("R1 fatal_err", 32'(fatal_err), 0);
    check("R1 stall_count", 32'(stall_count), 0);
  endtask

  task automatic t_idle();
    drive(1'b1, 1'b0, '0); check("R2 phase A", 32'(latch_en), 32'h15);
    drive(1'b1, 1'b0, '0);
    drive(1'b0, 1'b0, '0); check("R2 idle", 32'(latch_en), 0);
    drive(1'b0, 1'b1, '0); check("R2 phase B", 32'(latch_en), 32'h2A);
    drive(1'b0, 1'b1, '0);
    drive(1'b0, 1'b0, '0);
  endtask

  task automatic t_early();
    drive(1'b1, 1'b0, '0);
    drive(1'b1, 1'b0, '0);
    drive(1'b0, 1'b0, 6'b101010);            // odd stages, before B opens
    drive(1'b0, 1'b1, 6'b010101);            // even stages during B
    check("R3 no terr", 32'(timing_err), 0);
    drive(1'b0, 1'b1, '0);
    drive(1'b0, 1'b0, 6'b010101);            // even stages, before A opens
    check("R3 no terr", 32'(timing_err), 0);
    drive(1'b1, 1'b0, '0);
    check("R3 no fatal", 32'(fatal_err), 0);
    check("R3 A unblocked", 32'(latch_en), 32'h15);
    drive(1'b1, 1'b0, '0);
    drive(1'b0, 1'b0, '0);
    drive(1'b0, 1'b1, '0); check("R3 B unblocked", 32'(latch_en), 32'h2A);
    drive(1'b0, 1'b1, '0);
    drive(1'b0, 1'b0, '0);
  endtask

  task automatic t_single();
    base = 32'(stall_count);
    drive(1'b1, 1'b0, 6'b000100);            // stage 2 late
    check("R4 no early flag", 32'(timing_err), 0);
    drive(1'b1, 1'b0, '0);
    check("R4 terr", 32'(timing_err), 1);
    check("R4 not fatal", 32'(fatal_err), 0);
    drive(1'b0, 1'b0, '0);
    drive(1'b0, 1'b1, 6'b000010);            // stage 1 toggles while withheld
    check("R6 neighbours gated", 32'(latch_en), 32'h20);
    drive(1'b0, 1'b1, '0);
    check("R12 no terr when gated", 32'(timing_err), 0);
    check("R6 still gated", 32'(latch_en), 32'h20);
    drive(1'b0, 1'b0, '0);
    drive(1'b1, 1'b0, '0);
    check("R12 no fatal when gated", 32'(fatal_err), 0);
    check("R7 second ring", 32'(latch_en), 32'h04);
    check("R8 origin open", 32'(latch_en[2]), 1);
    check("R11 count +2", 32'(stall_count), base + 2);
    drive(1'b1, 1'b0, '0);
    drive(1'b0, 1'b0, '0);
    drive(1'b0, 1'b1, '0);
    check("R7 third ring", 32'(latch_en), 32'h0A);
    check("R11 count +4", 32'(stall_count), base + 4);
    drive(1'b0, 1'b1, '0);
    drive(1'b0, 1'b0, '0);
    drive(1'b1, 1'b0, '0);
    check("R10 A restored", 32'(latch_en), 32'h15);
    check("R11 count +5", 32'(stall_count), base + 5);
    drive(1'b1, 1'b0, '0);
    drive(1'b0, 1'b0, '0);
    drive(1'b0, 1'b1, '0);
    check("R10 B restored", 32'(latch_en), 32'h2A);
    drive(1'b0, 1'b1, '0);
    drive(1'b0, 1'b0, '0);
  endtask

  task automatic t_fatal();
    drive(1'b1, 1'b0, '0);
    drive(1'b1, 1'b0, '0);
    drive(1'b0, 1'b0, 6'b000100);            // stage 2 after close
    drive(1'b0, 1'b1, '0);
    check("R5 fatal", 32'(fatal_err), 1);
    check("R5 no terr", 32'(timing_err), 0);
    check("R5 no bubble", 32'(latch_en), 32'h2A);
    drive(1'b0, 1'b1, '0);
    check("R5 fatal clears", 32'(fatal_err), 0);
    drive(1'b0, 1'b0, '0);
    drive(1'b1, 1'b0, '0);
    check("R5 A open", 32'(latch_en), 32'h15);
    drive(1'b1, 1'b0, '0);
    drive(1'b0, 1'b0, '0);
    drive(1'b0, 1'b1, '0);
    drive(1'b0, 1'b1, '0);
    drive(1'b0, 1'b0, '0);
  endtask

  task automatic t_double();
    base = 32'(stall_count);
    drive(1'b1, 1'b0, 6'b010100);            // stages 2 and 4 late together
    drive(1'b1, 1'b0, '0);
    check("R4 terr double", 32'(timing_err), 1);
    drive(1'b0, 1'b0, '0);
    drive(1'b0, 1'b1, '0);
    check("R6 all odd gated", 32'(latch_en), 0);
    drive(1'b0, 1'b1, '0);
    drive(1'b0, 1'b0, '0);
    drive(1'b1, 1'b0, '0);
    check("R9 stages 0,4 gated", 32'(latch_en), 32'h04);
    check("R11 count +3", 32'(stall_count), base + 3);
    drive(1'b1, 1'b0, '0);
    drive(1'b0, 1'b0, '0);
    drive(1'b0, 1'b1, '0);
    check("R9 stage 5 once", 32'(latch_en), 32'h2A);
    check("R11 count +5", 32'(stall_count), base + 5);
    drive(1'b0, 1'b1, '0);
    drive(1'b0, 1'b0, '0);
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 14; k++) begin
      drive(1'b1, 1'b0, 6'b000100);
      drive(1'b1, 1'b0, '0);
      drive(1'b0, 1'b0, '0);
      for (int p = 0; p < 3; p++) begin
        drive(1'b0, 1'b1, '0); drive(1'b0, 1'b1, '0); drive(1'b0, 1'b0, '0);
        drive(1'b1, 1'b0, '0); drive(1'b1, 1'b0, '0); drive(1'b0, 1'b0, '0);
      end
      drive(1'b0, 1'b1, '0); drive(1'b0, 1'b1, '0); drive(1'b0, 1'b0, '0);
    end
    check("R11 saturates", 32'(stall_count), 32'(CMAX));
    rst = 1'b1;
    repeat (3) drive(1'b0, 1'b0, '0);
    rst = 1'b0;
    drive(1'b0, 1'b0, '0);
    check("R1 count cleared", 32'(stall_count), 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_early();
    t_single();
    t_fatal();
    t_double();
    t_saturate();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule